// File: doc/BRIEF.md
# Serial K-Best Survivor Selector

This block picks the K lowest-metric child nodes for one level of a breadth-first tree-search detector. Each of P parent nodes feeds its children to the block over its own valid/ready stream, cheapest child first. The block never sees a parent's full child list. It only looks at the child each parent is currently offering, called the head.

A single-cycle `start` pulse begins a selection run. In every cycle of the run, a comparison tree across the P heads finds the cheapest valid head. That head leaves as the next survivor, tagged with its parent index, symbol and metric. Only the winning parent gets `ready`, so in the next cycle that parent shows its next sibling and every other head stays where it was. After K survivors, `done` rises and holds until the next `start`. If every parent runs out of children first, the run stops early and `out_count` reports how many survivors were produced.

Top module: `kbest_serial_select`

## Requirements
- R1: After reset, `out_valid`, `done` and every `child_ready` bit are 0, and `out_count` is 0.
- R2: A `start` pulse clears `out_count` and `done`. The first survivor appears in the cycle right after the edge that samples `start`.
- R3: While a run is active, the survivor is the head with the smallest metric among the parents whose `child_valid` is high. When metrics are equal, the lower parent index wins.
- R4: In a survivor cycle, exactly one `child_ready` bit is high: bit p, where p is the winning parent. Outside survivor cycles no bit is high. A head with `ready` low is not consumed.
- R5: When every parent stream is ascending, the survivors of one run come out in non-decreasing metric order.
- R6: When enough children exist, exactly K survivors appear in K consecutive cycles. `done` is high in the cycle after the K-th survivor, with `out_count` = K, and stays high until the next `start`.
- R7: A parent with `child_valid` low is treated as exhausted, as if its metric were saturated. It is never chosen, even over a valid child whose metric is all ones.
- R8: Suppose all heads are invalid after n < K survivors. Then the cycle after the n-th survivor has no survivor, `done` is high one cycle later, and `out_count` = n.
- R9: Each survivor carries the winner's parent index on `out_parent`, its symbol on `out_sym` and its metric on `out_metric`. Parent p occupies bits [p*MW +: MW] of `child_metric` and bits [p*SW +: SW] of `child_sym`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Single-cycle pulse that starts a selection run |
| child_valid | input | P | Per parent: a head child is present |
| child_metric | input | P*MW | Per parent: metric of the head child |
| child_sym | input | P*SW | Per parent: symbol index of the head child |
| child_ready | output | P | Per parent: head consumed at this edge |
| out_valid | output | 1 | A survivor is presented this cycle |
| out_parent | output | IW | Parent index of the survivor |
| out_sym | output | SW | Symbol index of the survivor |
| out_metric | output | MW | Metric of the survivor |
| done | output | 1 | Run finished; held until the next start |
| out_count | output | CW | Survivors produced in the current run |

## Verification
Random runs use ascending parent lists of random length, including empty lists, over the full metric range. These show whether the survivor order matches a global stable sort of all children. Other random runs squeeze metrics into a range of eight values, which forces frequent ties between parents and inside one parent and so tests the lower-index tie rule and the single-advance handshake. Directed runs cover five cases:
- a two-parent example with interleaved metrics;
- all heads equal;
- no children at all, which exercises the early stop with a count of zero;
- a single valid child at the all-ones metric, which tests saturation against exhausted parents;
- one parent supplying every survivor.

// File: rtl/kbest_pkg.sv
package kbest_pkg;
   typedef enum logic [1:0] {
      KB_IDLE = 2'd0,
      KB_RUN  = 2'd1,
      KB_DONE = 2'd2
   } kb_state_e;
endpackage

// File: rtl/kbest_min_tree.sv
module kbest_min_tree #(
   parameter int P  = 3,
   parameter int MW = 8,
   localparam int IW = (P > 1) ? $clog2(P) : 1,
   localparam int LV = $clog2(P),
   localparam int NP = 1 << LV,
   localparam int NN = 2 * NP - 1
) (
   input  logic [P-1:0]    head_valid,
   input  logic [P*MW-1:0] head_metric,
   output logic            any_valid,
   output logic [IW-1:0]   win_idx,
   output logic [MW-1:0]   win_metric
);
   // key = {exhausted, metric}: an exhausted head sorts above any valid metric
   logic [MW:0]   key [NN];
   logic [IW-1:0] idx [NN];

   for (genvar i = 0; i < NP; i++) begin : g_leaf
      if (i < P) begin : g_real
         assign key[NP-1+i] = {~head_valid[i], head_metric[i*MW +: MW]};
      end else begin : g_pad
         assign key[NP-1+i] = '1;
      end
      assign idx[NP-1+i] = IW'(i);
   end

   for (genvar n = 0; n < NP - 1; n++) begin : g_node
      logic take_r;
      // right child wins only when strictly smaller: ties keep the lower index
      assign take_r = key[2*n+2] < key[2*n+1];
      assign key[n] = take_r ? key[2*n+2] : key[2*n+1];
      assign idx[n] = take_r ? idx[2*n+2] : idx[2*n+1];
   end

   assign any_valid  = ~key[0][MW];
   assign win_idx    = idx[0];
   assign win_metric = key[0][MW-1:0];

   always_comb begin
      if (any_valid) begin
         assert_win_is_live_R7: assert (head_valid[win_idx]);
      end
   end

   for (genvar i = 0; i < P; i++) begin : g_chk
      always_comb begin
         if (any_valid && head_valid[i]) begin
            assert_win_minimal_R3: assert (win_metric <= head_metric[i*MW +: MW]);
         end
      end
   end
endmodule

// File: rtl/kbest_ctrl.sv
module kbest_ctrl
   import kbest_pkg::*;
#(
   parameter int K = 4,
   localparam int CW = $clog2(K + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          any_valid,
   output logic          emit,
   output logic          done,
   output logic [CW-1:0] count
);
   kb_state_e     state_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= KB_IDLE;
         cnt_q   <= '0;
      end else if (start) begin
         state_q <= KB_RUN;
         cnt_q   <= '0;
      end else if (state_q == KB_RUN) begin
         if (any_valid) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(K - 1)) state_q <= KB_DONE;
         end else begin
            state_q <= KB_DONE;
         end
      end
   end

   assign emit  = (state_q == KB_RUN) && any_valid;
   assign done  = (state_q == KB_DONE);
   assign count = cnt_q;

   assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(K));
   assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !emit);
   assert_early_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(done) && count != CW'(K)) |-> !$past(any_valid));
endmodule

// File: rtl/kbest_serial_select.sv
module kbest_serial_select #(
   parameter int K  = 4,
   parameter int P  = 3,
   parameter int MW = 8,
   parameter int SW = 4,
   localparam int IW = (P > 1) ? $clog2(P) : 1,
   localparam int CW = $clog2(K + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [P-1:0]    child_valid,
   input  logic [P*MW-1:0] child_metric,
   input  logic [P*SW-1:0] child_sym,
   output logic [P-1:0]    child_ready,
   output logic            out_valid,
   output logic [IW-1:0]   out_parent,
   output logic [SW-1:0]   out_sym,
   output logic [MW-1:0]   out_metric,
   output logic            done,
   output logic [CW-1:0]   out_count
);
   if (K < 1)  begin : g_bad_k  $error("K must be at least 1");  end
   if (P < 1)  begin : g_bad_p  $error("P must be at least 1");  end
   if (MW < 1) begin : g_bad_mw $error("MW must be at least 1"); end
   if (SW < 1) begin : g_bad_sw $error("SW must be at least 1"); end

   logic          any_valid;
   logic          emit;
   logic [IW-1:0] win_idx;
   logic [MW-1:0] win_metric;

   kbest_min_tree #(.P(P), .MW(MW)) tree_i (
      .head_valid (child_valid),
      .head_metric(child_metric),
      .any_valid  (any_valid),
      .win_idx    (win_idx),
      .win_metric (win_metric)
   );

   kbest_ctrl #(.K(K)) ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .any_valid(any_valid),
      .emit     (emit),
      .done     (done),
      .count    (out_count)
   );

   always_comb begin
      out_sym     = '0;
      child_ready = '0;
      for (int p = 0; p < P; p++) begin
         if (win_idx == IW'(p)) begin
            out_sym        = child_sym[p*SW +: SW];
            child_ready[p] = emit;
         end
      end
   end

   assign out_valid  = emit;
   assign out_parent = win_idx;
   assign out_metric = win_metric;

   assert_one_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(child_ready));
   assert_winner_present_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> child_valid[out_parent]);
   assert_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid) && !$past(start)) |-> out_metric >= $past(out_metric));
endmodule

// File: tb/kbest_serial_select_tb.sv
`timescale 1ns/1ps
module kbest_serial_select_tb_top;
   localparam int K = 4, P = 3, MW = 8, SW = 4, IW = 2, CW = 3;
   localparam int MAXC = 6;
   localparam int NE = P * MAXC;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [P-1:0]    child_valid;
   logic [P*MW-1:0] child_metric;
   logic [P*SW-1:0] child_sym;
   logic [P-1:0]    child_ready;
   logic            out_valid;
   logic [IW-1:0]   out_parent;
   logic [SW-1:0]   out_sym;
   logic [MW-1:0]   out_metric;
   logic            done;
   logic [CW-1:0]   out_count;

   logic [MW-1:0] lst_m [P][MAXC+1];
   logic [SW-1:0] lst_s [P][MAXC+1];
   int ncnt [P];
   int ptr  [P];

   int vectors = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   always_comb begin
      for (int i = 0; i < P; i++) begin
         child_valid[i]          = ptr[i] < ncnt[i];
         child_metric[i*MW +: MW] = lst_m[i][ptr[i]];
         child_sym[i*SW +: SW]    = lst_s[i][ptr[i]];
      end
   end

   kbest_serial_select #(.K(K), .P(P), .MW(MW), .SW(SW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .child_valid(child_valid), .child_metric(child_metric), .child_sym(child_sym),
      .child_ready(child_ready), .out_valid(out_valid), .out_parent(out_parent),
      .out_sym(out_sym), .out_metric(out_metric), .done(done), .out_count(out_count)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_lists();
      for (int i = 0; i < P; i++) begin
         ncnt[i] = 0;
         for (int c = 0; c <= MAXC; c++) begin
            lst_m[i][c] = '0;
            lst_s[i][c] = '0;
         end
      end
   endtask

   task automatic push(input int p, input int m, input int s);
      lst_m[p][ncnt[p]] = MW'(m);
      lst_s[p][ncnt[p]] = SW'(s);
      ncnt[p]++;
   endtask

   task automatic run_trial();
      logic [MW-1:0] em [NE];
      int            ep [NE];
      logic [SW-1:0] es [NE];
      int total = 0;
      int e_n;
      logic [P-1:0] rdy;
      // all children in parent then sibling order; stable sort by metric
      for (int i = 0; i < P; i++) begin
         for (int c = 0; c < ncnt[i]; c++) begin
            int j = total;
            while (j > 0 && em[j-1] > lst_m[i][c]) begin
               em[j] = em[j-1]; ep[j] = ep[j-1]; es[j] = es[j-1];
               j--;
            end
            em[j] = lst_m[i][c]; ep[j] = i; es[j] = lst_s[i][c];
            total++;
         end
      end
      e_n = (total < K) ? total : K;
      @(negedge clk);
      for (int i = 0; i < P; i++) ptr[i] = 0;
      start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      for (int j = 0; j < e_n; j++) begin
         @(negedge clk);
         check("R2 out_valid", 32'(out_valid), 32'd1);
         check("R3 R5 out_metric", 32'(out_metric), 32'(em[j]));
         check("R3 R7 out_parent", 32'(out_parent), 32'(ep[j]));
         check("R9 out_sym", 32'(out_sym), 32'(es[j]));
         check("R4 child_ready", 32'(child_ready), 32'(1 << ep[j]));
         check("R2 R6 out_count", 32'(out_count), 32'(j));
         check("R6 done low", 32'(done), 32'd0);
         rdy = child_ready;
         @(posedge clk); #1;
         for (int i = 0; i < P; i++) if (rdy[i]) ptr[i]++;
      end
      if (e_n < K) begin
         @(negedge clk);
         check("R8 no survivor", 32'(out_valid), 32'd0);
         check("R7 R8 no ready", 32'(child_ready), 32'd0);
         check("R8 done not yet", 32'(done), 32'd0);
      end
      @(negedge clk);
      check("R6 R8 done", 32'(done), 32'd1);
      check("R6 quiet", 32'(out_valid), 32'd0);
      check("R6 R8 out_count", 32'(out_count), 32'(e_n));
      @(negedge clk);
      check("R6 done held", 32'(done), 32'd1);
      check("R4 no ready after done", 32'(child_ready), 32'd0);
   endtask

   task automatic random_lists(input int mmax);
      clear_lists();
      for (int i = 0; i < P; i++) begin
         int n = $urandom_range(MAXC, 0);
         int v [MAXC];
         for (int c = 0; c < n; c++) v[c] = $urandom_range(mmax, 0);
         for (int a = 1; a < n; a++) begin
            int t = v[a];
            int b = a;
            while (b > 0 && v[b-1] > t) begin v[b] = v[b-1]; b--; end
            v[b] = t;
         end
         for (int c = 0; c < n; c++) push(i, v[c], $urandom_range(15, 0));
      end
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20151));
      clear_lists();
      for (int i = 0; i < P; i++) ptr[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      check("R1 out_valid", 32'(out_valid), 32'd0);
      check("R1 done", 32'(done), 32'd0);
      check("R1 out_count", 32'(out_count), 32'd0);
      check("R1 child_ready", 32'(child_ready), 32'd0);

      // interleaved two-parent example
      clear_lists();
      push(0, 10, 1); push(0, 31, 2); push(1, 20, 3); push(1, 40, 4);
      run_trial();
      // all heads equal: lower parent wins, same parent again after advance
      clear_lists();
      for (int i = 0; i < P; i++) begin push(i, 5, i); push(i, 5, i + 8); end
      run_trial();
      // nothing to select
      clear_lists();
      run_trial();
      // valid all-ones metric beats exhausted parents
      clear_lists();
      push(1, 255, 9);
      run_trial();
      // one parent supplies every survivor
      clear_lists();
      for (int c = 0; c < MAXC; c++) push(2, c + 1, c);
      push(0, 200, 1); push(1, 201, 2);
      run_trial();

      for (int t = 0; t < 300; t++) begin
         random_lists((t % 2 == 0) ? 255 : 7);
         run_trial();
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule